// File: doc/BRIEF.md
# Power-Management Event Aggregator with SMI/SCI Steering

This block gathers power-management and trap events into sticky status bits. The events are a write to the APM command port, expiry of the software-SMI timer, a blocked firmware write, a power-button override, a set of external sources, and the low sixteen general-purpose inputs. Each status bit has its own enable bit. Together the enabled bits form one pending condition. A single mode bit decides where that condition goes. In SCI mode it drives a level interrupt that can be routed to one of seven interrupt lines. In the other mode it drives a system-management interrupt (SMI).

The SMI output is one-shot. Once raised, it stays high until software writes the end-of-SMI bit. Only then can a new SMI be raised. The SMI path is also gated by a global SMI enable. A small register port with a fixed address map gives access to control, status (write 1 to clear) and enables. Reads return data one cycle after the address is presented.

Top module: `pm_event_agg`

## Requirements
- R1: Each status bit is set by its event whether or not its enable bit is set. It clears only when 1 is written to its position at the status address (1 for events, 3 for GPI). Writing 0 has no effect. Event status bit positions are: 0 APM port, 1 timer, 2 firmware write, 3 power-button override, 4 and up external events.
- R2: When control bit 0 (SCI mode) is 0, control bit 1 (global SMI enable) is 1, and any enabled status bit is set, `smi_out` rises. It rises on the clock edge after the one that set the enabling register or the status bit.
- R3: `smi_out` never rises while global SMI enable is 0.
- R4: Once high, `smi_out` stays high even after all status is cleared. It falls only on the edge that writes 1 to control bit 2 (end-of-SMI). If an enabled status bit is still set, it rises again on the next edge.
- R5: In SCI mode, `sci_out` is high exactly while some enabled status bit is set, and `smi_out` is not raised.
- R6: Control bits [10:8] choose the route for SCI. Codes 0, 1 and 2 give lines 9, 10 and 11 (`sci_line` bits 0, 1 and 2). Codes 3 to 6 give lines 20 to 23 (bits 3 to 6), but only when control bit 4 (APIC mode) is 1. Code 7, or an upper code without APIC mode, drives no line. `sci_line` is zero whenever `sci_out` is low.
- R7: `io_wr` with `io_addr` equal to 0x00B2 sets status bit 0. A write to any other address does not.
- R8: While enable bit 1 is set, the timer sets status bit 1 every TMR_TICKS cycles. While enable bit 1 is clear, the timer is held at zero.
- R9: `fw_wr` sets status bit 2 only while control bit 3 (write protect) is 1.
- R10: GPI inputs 0 to 15 latch into GPI status at address 3, with enables at address 4. Inputs 16 and above are ignored.
- R11: A power-button-override status bit that is already set and enabled raises `sci_out` as soon as SCI mode is entered.
- R12: After reset, all registers read 0 and `smi_out`, `sci_out` and `sci_line` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1 status, 2 enable, 3 GPI status, 4 GPI enable) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| io_wr | input | 1 | I/O write seen on the bus |
| io_addr | input | 16 | Address of that I/O write |
| fw_wr | input | 1 | Write attempt to the protected firmware region |
| pwrbtn_ovr | input | 1 | Power-button override event |
| ext_evt | input | NUM_EXT | External event pulses |
| gpi_evt | input | GPI_W | General-purpose input events |
| smi_out | output | 1 | System-management interrupt, held until end-of-SMI |
| sci_out | output | 1 | Level SCI request |
| sci_line | output | 7 | One-hot SCI route (lines 9, 10, 11, 20, 21, 22, 23) |

## Verification
The bench builds the block with NUM_EXT=4, GPI_W=20 and TMR_TICKS=40. The short timer period makes timer expiry observable within a few dozen cycles. GPI_W=20 provides inputs above 15, which must be shown to be ignored. Four external sources keep the random status masks small enough to hit every mix of set and enabled bits. Every route code is driven with and without APIC mode.

// File: rtl/pm_agg_pkg.sv
package pm_agg_pkg;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STS  = 3'd1;
  localparam logic [2:0] A_EN   = 3'd2;
  localparam logic [2:0] A_GSTS = 3'd3;
  localparam logic [2:0] A_GEN  = 3'd4;

  localparam int C_SCI  = 0;
  localparam int C_GBL  = 1;
  localparam int C_EOS  = 2;
  localparam int C_WP   = 3;
  localparam int C_APIC = 4;
  localparam int C_RT   = 8;

  localparam int EVT_APM   = 0;
  localparam int EVT_TMR   = 1;
  localparam int EVT_FW    = 2;
  localparam int EVT_PWR   = 3;
  localparam int EVT_FIXED = 4;

  localparam int GPI_SRC   = 16;
  localparam int SCI_LINES = 7;
  localparam int LOW_LINES = 3;
  localparam logic [15:0] APM_PORT = 16'h00B2;

  typedef struct packed {
    logic [2:0] route;
    logic       apic;
    logic       wp;
    logic       gbl;
    logic       sci;
  } ctrl_t;
endpackage

// File: rtl/pm_sticky_bank.sv
module pm_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] sts
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) sts <= '0;
    else     sts <= (sts & ~clr_eff) | set_i;
  end
endmodule

// File: rtl/pm_swsmi_timer.sv
module pm_swsmi_timer #(
  parameter int TICKS = 8_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic hit
);
  localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      hit <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      hit <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      hit <= 1'b0;
    end
  end
endmodule

// File: rtl/pm_sci_router.sv
module pm_sci_router #(
  parameter int LINES = 7,
  parameter int LOW   = 3
) (
  input  logic             active,
  input  logic [2:0]       route,
  input  logic             apic,
  output logic [LINES-1:0] line
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i < LOW) begin : g_low
      assign line[i] = active && (route == 3'(i));
    end else begin : g_high
      assign line[i] = active && apic && (route == 3'(i));
    end
  end
endmodule

// File: rtl/pm_event_agg.sv
module pm_event_agg
  import pm_agg_pkg::*;
#(
  parameter int NUM_EXT   = 8,
  parameter int GPI_W     = 32,
  parameter int TMR_TICKS = 8_000_000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 io_wr,
  input  logic [15:0]          io_addr,
  input  logic                 fw_wr,
  input  logic                 pwrbtn_ovr,
  input  logic [NUM_EXT-1:0]   ext_evt,
  input  logic [GPI_W-1:0]     gpi_evt,
  output logic                 smi_out,
  output logic                 sci_out,
  output logic [SCI_LINES-1:0] sci_line
);
  localparam int EV_W = EVT_FIXED + NUM_EXT;
  localparam int GU   = (GPI_W < GPI_SRC) ? GPI_W : GPI_SRC;

  ctrl_t          ctrl;
  logic [EV_W-1:0] ev_sts, ev_en, ev_set;
  logic [GU-1:0]   g_sts, g_en;
  logic            tmr_hit, pend, eos_wr, in_smi, wr_ctrl;
  logic [SCI_LINES-1:0] line_d;
  logic            unused_bits;

  assign unused_bits = ^{reg_wdata, gpi_evt};
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign eos_wr  = wr_ctrl && reg_wdata[C_EOS];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      ev_en <= '0;
      g_en  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL: ctrl <= '{route: reg_wdata[C_RT+2:C_RT], apic: reg_wdata[C_APIC],
                          wp: reg_wdata[C_WP], gbl: reg_wdata[C_GBL], sci: reg_wdata[C_SCI]};
        A_EN:   ev_en <= reg_wdata[EV_W-1:0];
        A_GEN:  g_en  <= reg_wdata[GU-1:0];
        default: ;
      endcase
    end
  end

  pm_swsmi_timer #(.TICKS(TMR_TICKS)) u_tmr (
    .clk(clk), .rst(rst), .run(ev_en[EVT_TMR]), .hit(tmr_hit)
  );

  always_comb begin
    ev_set = '0;
    ev_set[EVT_APM] = io_wr && (io_addr == APM_PORT);
    ev_set[EVT_TMR] = tmr_hit;
    ev_set[EVT_FW]  = fw_wr && ctrl.wp;
    ev_set[EVT_PWR] = pwrbtn_ovr;
    ev_set[EV_W-1:EVT_FIXED] = ext_evt;
  end

  pm_sticky_bank #(.W(EV_W)) u_ev (
    .clk(clk), .rst(rst), .set_i(ev_set),
    .clr_we(reg_wr && (reg_addr == A_STS)), .clr_mask(reg_wdata[EV_W-1:0]), .sts(ev_sts)
  );

  pm_sticky_bank #(.W(GU)) u_gpi (
    .clk(clk), .rst(rst), .set_i(gpi_evt[GU-1:0]),
    .clr_we(reg_wr && (reg_addr == A_GSTS)), .clr_mask(reg_wdata[GU-1:0]), .sts(g_sts)
  );

  assign pend = (|(ev_sts & ev_en)) || (|(g_sts & g_en));

  always_ff @(posedge clk) begin
    if (rst)                                          in_smi <= 1'b0;
    else if (eos_wr)                                  in_smi <= 1'b0;
    else if (!in_smi && pend && ctrl.gbl && !ctrl.sci) in_smi <= 1'b1;
  end
  assign smi_out = in_smi;

  pm_sci_router #(.LINES(SCI_LINES), .LOW(LOW_LINES)) u_rt (
    .active(ctrl.sci && pend), .route(ctrl.route), .apic(ctrl.apic), .line(line_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sci_out  <= 1'b0;
      sci_line <= '0;
    end else begin
      sci_out  <= ctrl.sci && pend;
      sci_line <= line_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_CTRL: reg_rdata <= 32'({ctrl.route, 3'b000, ctrl.apic, ctrl.wp, 1'b0, ctrl.gbl, ctrl.sci});
        A_STS:  reg_rdata <= 32'(ev_sts);
        A_EN:   reg_rdata <= 32'(ev_en);
        A_GSTS: reg_rdata <= 32'(g_sts);
        A_GEN:  reg_rdata <= 32'(g_en);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pm_event_agg_chk.sv
module pm_event_agg_chk
  import pm_agg_pkg::*;
#(
  parameter int EV_W = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_wr,
  input logic [2:0]           reg_addr,
  input logic [31:0]          reg_wdata,
  input logic                 smi_out,
  input logic                 sci_out,
  input logic [SCI_LINES-1:0] sci_line,
  input logic                 m_sci,
  input logic                 m_gbl,
  input logic                 m_apic,
  input logic [EV_W-1:0]      ev_sts
);
  logic eos_w, clr_w;
  assign eos_w = reg_wr && (reg_addr == A_CTRL) && reg_wdata[C_EOS];
  assign clr_w = reg_wr && (reg_addr == A_STS);

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|($past(ev_sts) & ~ev_sts)) |-> $past(clr_w)); // R1
  AST_SMI_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(smi_out) |-> $past(m_gbl && !m_sci)); // R3
  AST_SMI_HELD: assert property (@(posedge clk) disable iff (rst)
    (smi_out && !eos_w) |=> smi_out); // R4
  AST_SCI_MODE: assert property (@(posedge clk) disable iff (rst)
    sci_out |-> $past(m_sci)); // R5
  AST_LINE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sci_line) && (sci_out || sci_line == '0)); // R6
  AST_UPPER_APIC: assert property (@(posedge clk) disable iff (rst)
    (|sci_line[SCI_LINES-1:LOW_LINES]) |-> $past(m_apic)); // R6
endmodule

bind pm_event_agg pm_event_agg_chk #(.EV_W(pm_agg_pkg::EVT_FIXED + NUM_EXT)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .smi_out(smi_out), .sci_out(sci_out), .sci_line(sci_line),
  .m_sci(ctrl.sci), .m_gbl(ctrl.gbl), .m_apic(ctrl.apic), .ev_sts(ev_sts)
);

// File: tb/sim_pm_event_agg.sv
`timescale 1ns/1ps
module sim_pm_event_agg;
  localparam int NE = 4, GW = 20, TK = 40, EW = 4 + NE;
  logic clk = 0, rst = 1;
  logic reg_wr = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic io_wr = 0; logic [15:0] io_addr = 0; logic fw_wr = 0, pwrbtn_ovr = 0;
  logic [NE-1:0] ext_evt = 0; logic [GW-1:0] gpi_evt = 0;
  logic smi_out, sci_out; logic [6:0] sci_line;
  int checks = 0, errors = 0;
  logic [EW-1:0] m_sts; logic [15:0] m_gsts;

  always #4 clk = ~clk;

  pm_event_agg #(.NUM_EXT(NE), .GPI_W(GW), .TMR_TICKS(TK)) u0 (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(posedge clk); @(negedge clk); d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl(input bit sci, gbl, eos, wp, apic, input logic [2:0] rt);
    return {21'd0, rt, 3'd0, apic, wp, eos, gbl, sci};
  endfunction

  function automatic logic [6:0] exp_line(input bit act, input logic [2:0] rt, input bit apic);
    if (!act || rt == 3'd7) return 7'd0;
    if (rt < 3) return 7'(1 << rt);
    return apic ? 7'(1 << rt) : 7'd0;
  endfunction

  task automatic idle(input int n); repeat (n) @(posedge clk); @(negedge clk); endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, en, gen, c, clr;
    bit apic, wp; logic [2:0] rt;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk); @(negedge clk); rst = 0;
    // R12 reset state
    chk(!smi_out && !sci_out && sci_line == 0, "R12", {sci_line, sci_out, smi_out}, 0);
    for (int a = 0; a < 5; a++) begin rd(3'(a), d); chk(d == 0, "R12", d, 0); end

    // Random phase in SCI mode: R1 R5 R6 R7 R9 R10
    m_sts = 0; m_gsts = 0;
    for (int it = 0; it < 60; it++) begin
      en = $urandom & 32'(((1 << EW) - 1) & ~2); gen = $urandom & 32'hFFFF;
      apic = $urandom_range(0, 1); wp = $urandom_range(0, 1); rt = 3'($urandom_range(0, 7));
      wr(3'd2, en); wr(3'd4, gen); wr(3'd0, ctl(1, 0, 0, wp, apic, rt));
      @(negedge clk);
      ext_evt = NE'($urandom); gpi_evt = GW'($urandom); pwrbtn_ovr = $urandom_range(0, 1);
      fw_wr = $urandom_range(0, 1); io_wr = $urandom_range(0, 1);
      io_addr = $urandom_range(0, 1) ? 16'h00B2 : 16'(16'h00B3 + $urandom_range(0, 60));
      m_sts |= {ext_evt, pwrbtn_ovr, fw_wr & wp, 1'b0, io_wr && io_addr == 16'h00B2};
      m_gsts |= gpi_evt[15:0];
      @(negedge clk); ext_evt = 0; gpi_evt = 0; pwrbtn_ovr = 0; fw_wr = 0; io_wr = 0;
      idle(2);
      rd(3'd1, d); chk(d == 32'(m_sts), "R1 R7 R9 status", d, 32'(m_sts));
      rd(3'd3, d); chk(d == 32'(m_gsts), "R10 gpi status", d, 32'(m_gsts));
      begin
        bit act; act = (|(32'(m_sts) & en)) || (|(32'(m_gsts) & gen));
        chk(sci_out == act && !smi_out, "R5", {smi_out, sci_out}, {1'b0, act});
        chk(sci_line == exp_line(act, rt, apic), "R6", sci_line, exp_line(act, rt, apic));
      end
      clr = $urandom; wr(3'd1, clr); m_sts &= ~clr[EW-1:0];
      clr = $urandom; wr(3'd3, clr); m_gsts &= ~clr[15:0];
    end
    wr(3'd1, '1); wr(3'd3, '1); wr(3'd4, 0);

    // R6 every route with and without APIC
    wr(3'd2, 32'h10); @(negedge clk); ext_evt = 1; @(negedge clk); ext_evt = 0;
    for (int a = 0; a < 2; a++)
      for (int r = 0; r < 8; r++) begin
        wr(3'd0, ctl(1, 0, 0, 0, a[0], 3'(r))); idle(2);
        chk(sci_line == exp_line(1, 3'(r), a[0]), "R6 route", sci_line, exp_line(1, 3'(r), a[0]));
      end
    wr(3'd1, '1); wr(3'd2, 0); wr(3'd0, 0);

    // R1 write of 0 keeps, W1C clears, enable not needed
    @(negedge clk); ext_evt = 4'b0010; @(negedge clk); ext_evt = 0;
    wr(3'd1, 0); rd(3'd1, d); chk(d == 32'h20, "R1 sticky", d, 32'h20);
    wr(3'd1, 32'h20); rd(3'd1, d); chk(d == 0, "R1 clear", d, 0);

    // R7 non-matching port then 0xB2
    @(negedge clk); io_wr = 1; io_addr = 16'h00B3; @(negedge clk); io_wr = 0;
    rd(3'd1, d); chk(d == 0, "R7 other port", d, 0);
    @(negedge clk); io_wr = 1; io_addr = 16'h00B2; @(negedge clk); io_wr = 0;
    rd(3'd1, d); chk(d == 1, "R7 APM port", d, 1); wr(3'd1, '1);

    // R9 firmware write with and without protection
    @(negedge clk); fw_wr = 1; @(negedge clk); fw_wr = 0;
    rd(3'd1, d); chk(d == 0, "R9 unprotected", d, 0);
    wr(3'd0, ctl(0, 0, 0, 1, 0, 0));
    @(negedge clk); fw_wr = 1; @(negedge clk); fw_wr = 0;
    rd(3'd1, d); chk(d == 4, "R9 protected", d, 4); wr(3'd1, '1);

    // R10 input above 15 ignored
    @(negedge clk); gpi_evt = GW'(1) << 17; @(negedge clk); gpi_evt = 0;
    rd(3'd3, d); chk(d == 0, "R10 high gpi", d, 0);
    @(negedge clk); gpi_evt = GW'(1) << 15; @(negedge clk); gpi_evt = 0;
    rd(3'd3, d); chk(d == 32'h8000, "R10 gpi15", d, 32'h8000); wr(3'd3, '1);

    // R3 then R2: pending with global enable off, then on
    wr(3'd0, 0); wr(3'd2, 32'h10);
    @(negedge clk); ext_evt = 1; @(negedge clk); ext_evt = 0;
    idle(4); chk(!smi_out, "R3 gbl off", smi_out, 0);
    wr(3'd0, ctl(0, 1, 0, 0, 0, 0));
    chk(!smi_out, "R2 latency low", smi_out, 0);
    idle(1); chk(smi_out, "R2 raised", smi_out, 1);

    // R4 held after clear, released by end-of-SMI, re-fires
    wr(3'd1, '1); idle(3); chk(smi_out, "R4 held", smi_out, 1);
    wr(3'd0, ctl(0, 1, 1, 0, 0, 0)); chk(!smi_out, "R4 eos drop", smi_out, 0);
    idle(4); chk(!smi_out, "R4 stays low", smi_out, 0);
    @(negedge clk); ext_evt = 1; @(negedge clk); ext_evt = 0;
    idle(2); chk(smi_out, "R4 next smi", smi_out, 1);
    wr(3'd0, ctl(0, 1, 1, 0, 0, 0)); chk(!smi_out, "R4 eos pending", smi_out, 0);
    idle(1); chk(smi_out, "R4 refire", smi_out, 1);
    wr(3'd1, '1); wr(3'd0, ctl(0, 0, 1, 0, 0, 0)); wr(3'd2, 0);

    // R11 residual power-button status then SCI mode; R5 no SMI
    @(negedge clk); pwrbtn_ovr = 1; @(negedge clk); pwrbtn_ovr = 0;
    wr(3'd2, 32'h8); idle(3);
    chk(!sci_out && !smi_out, "R11 before mode", {smi_out, sci_out}, 0);
    wr(3'd0, ctl(1, 1, 0, 0, 0, 3'd1)); idle(2);
    chk(sci_out && sci_line == 7'b10, "R11 sci", {sci_line, sci_out}, {7'b10, 1'b1});
    chk(!smi_out, "R5 no smi", smi_out, 0);
    wr(3'd1, '1); idle(2); chk(!sci_out, "R5 sci drop", sci_out, 1'b0);
    wr(3'd0, 0); wr(3'd2, 0);

    // R8 timer
    idle(TK + 2); rd(3'd1, d); chk(d == 0, "R8 stopped", d, 0);
    wr(3'd2, 32'h2);
    repeat (TK - 6) @(posedge clk);
    rd(3'd1, d); chk(d[1] == 0, "R8 early", d, 0);
    repeat (8) @(posedge clk);
    rd(3'd1, d); chk(d[1] == 1, "R8 expiry", d, 2);
    wr(3'd1, '1); repeat (TK - 6) @(posedge clk);
    rd(3'd1, d); chk(d[1] == 0, "R8 second early", d, 0);
    repeat (8) @(posedge clk);
    rd(3'd1, d); chk(d[1] == 1, "R8 second expiry", d, 2);
    wr(3'd2, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule